// File: doc/BRIEF.md
# Time-Slotted Shared RAM Scheduler

This block lets three clients share one single-port working RAM without any arbitration by request. The clients are a loader that writes fresh samples, an unloader that reads finished results, and a compute engine that both reads and writes intermediate values. A free-running phase counter divides time into repeating frames of twelve system-clock cycles. Each phase belongs to exactly one client. A client that has work pending when its phase comes up drives the RAM port for that cycle. If it has no work, the RAM stays idle for that cycle.

The unloader owns two phases per frame, spaced half a frame apart. A pulse on the dump request input is therefore served within six cycles. When that read completes, a sticky flag tells the output side that results have reached its buffer. The flag stays set until the output side acknowledges it. The RAM has one cycle of read latency. Read data returns on the port of the client that owned the slot, together with a valid strobe, one cycle after the slot.

Top module: `slot_ram_sched`

## Requirements
- R1: A phase counter steps 0,1,...,11 and wraps to 0. One step is one clock cycle.
- R2: The unloader is granted only at phases 0 and 6. It is granted when it raises its read request or when a dump request is pending, and it always performs a read.
- R3: The loader is granted only at phases 1 and 7, and only when it raises its request. Its access is always a write.
- R4: The compute engine owns the other eight phases (2–5, 8–11). It is granted when it requests, and its write-enable input selects write (1) or read (0).
- R5: In a slot whose owner has no work, the RAM enable, write enable, address and write data are all driven to 0.
- R6: At most one grant is active in any cycle. The RAM address and write data are those of the granted client.
- R7: A granted read returns the RAM data one cycle later on the owning client's data port, with that client's valid strobe high. A data port reads 0 while its valid strobe is low.
- R8: A dump request pulse makes a request pending unless one is already pending. The loaded flag rises no more than 7 cycles after the pulse. A pulse in the same cycle as a serving grant starts a new pending request.
- R9: The loaded flag is set by the output-slot read that serves a pending dump. It then holds until an acknowledge, which clears it. If a set and an acknowledge occur in the same cycle, the set wins.
- R10: A synchronous reset returns the phase to 0 and clears the pending dump, the loaded flag and both valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Loader has a sample to write |
| in_addr | input | AW | Loader write address |
| in_wdata | input | DW | Loader write data |
| out_req | input | 1 | Unloader wants a read |
| out_addr | input | AW | Unloader read address |
| dump_go | input | 1 | Pulse: finished results are ready to dump |
| out_ack | input | 1 | Output side acknowledges the loaded flag |
| eng_req | input | 1 | Engine wants an access |
| eng_we | input | 1 | Engine access is a write |
| eng_addr | input | AW | Engine address |
| eng_wdata | input | DW | Engine write data |
| phase | output | 4 | Current slot phase |
| gnt_in | output | 1 | Loader granted this cycle |
| gnt_out | output | 1 | Unloader granted this cycle |
| gnt_eng | output | 1 | Engine granted this cycle |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after the access |
| out_rvalid | output | 1 | Unloader read data valid |
| out_rdata | output | DW | Unloader read data |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | DW | Engine read data |
| loaded | output | 1 | Sticky: dumped results are in the output buffer |

## Verification
The bench builds the block with AW=4 and DW=8. The 16-word RAM makes the three clients hit the same addresses often, so a write followed by a read is tested through real data. The narrow data width keeps the values easy to read in failure messages. Dump requests are started at each of the twelve phases, which exercises both the best-case and the worst-case wait before the next output slot. A reset issued while a dump is pending shows that the pending request is discarded.

// File: rtl/slot_ram_sched.sv
module slot_ram_sched #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_req,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          out_req,
  input  logic [AW-1:0] out_addr,
  input  logic          dump_go,
  input  logic          out_ack,
  input  logic          eng_req,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic [3:0]    phase,
  output logic          gnt_in,
  output logic          gnt_out,
  output logic          gnt_eng,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          out_rvalid,
  output logic [DW-1:0] out_rdata,
  output logic          eng_rvalid,
  output logic [DW-1:0] eng_rdata,
  output logic          loaded
);
  localparam logic [3:0] LAST = 4'd11;
  localparam logic [3:0] HALF = 4'd6;

  logic slot_out, slot_in, slot_eng, eng_wr, dump_pend;

  always_ff @(posedge clk)
    if (rst || phase == LAST) phase <= '0;
    else                      phase <= phase + 4'd1;

  assign slot_out = (phase == 4'd0) || (phase == HALF);
  assign slot_in  = (phase == 4'd1) || (phase == HALF + 4'd1);
  assign slot_eng = !slot_out && !slot_in;

  assign gnt_out = slot_out && (out_req || dump_pend);
  assign gnt_in  = slot_in && in_req;
  assign gnt_eng = slot_eng && eng_req;
  assign eng_wr  = gnt_eng && eng_we;

  assign ram_en    = gnt_out || gnt_in || gnt_eng;
  assign ram_we    = gnt_in || eng_wr;
  assign ram_addr  = gnt_in  ? in_addr  :
                     gnt_out ? out_addr :
                     gnt_eng ? eng_addr : '0;
  assign ram_wdata = gnt_in ? in_wdata : eng_wr ? eng_wdata : '0;

  always_ff @(posedge clk)
    if (rst) begin
      out_rvalid <= 1'b0;
      eng_rvalid <= 1'b0;
      dump_pend  <= 1'b0;
      loaded     <= 1'b0;
    end else begin
      out_rvalid <= gnt_out;
      eng_rvalid <= gnt_eng && !eng_we;
      dump_pend  <= dump_go || (dump_pend && !gnt_out);
      if (gnt_out && dump_pend) loaded <= 1'b1;
      else if (out_ack)         loaded <= 1'b0;
    end

  assign out_rdata = out_rvalid ? ram_rdata : '0;
  assign eng_rdata = eng_rvalid ? ram_rdata : '0;
endmodule

module slot_ram_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] phase,
  input logic       gnt_in,
  input logic       gnt_out,
  input logic       gnt_eng,
  input logic       ram_en,
  input logic       ram_we,
  input logic       out_rvalid,
  input logic       eng_rvalid,
  input logic       loaded,
  input logic       out_ack,
  input logic       dump_pend
);
  logic [3:0] wait_cnt;
  always_ff @(posedge clk)
    if (rst) wait_cnt <= '0;
    else     wait_cnt <= (dump_pend && !gnt_out) ? wait_cnt + 4'd1 : 4'd0;

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst) phase == 4'd11 |=> phase == 4'd0); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) phase != 4'd11 |=> phase == 4'($past(phase) + 4'd1)); // R1
  AST_OUT_SLOT: assert property (@(posedge clk) disable iff (rst) gnt_out |-> ((phase == 4'd0 || phase == 4'd6) && !ram_we)); // R2
  AST_IN_SLOT: assert property (@(posedge clk) disable iff (rst) gnt_in |-> ((phase == 4'd1 || phase == 4'd7) && ram_we)); // R3
  AST_ENG_SLOT: assert property (@(posedge clk) disable iff (rst) gnt_eng |-> !(phase == 4'd0 || phase == 4'd6 || phase == 4'd1 || phase == 4'd7)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !ram_en |-> !ram_we); // R5
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0({gnt_in, gnt_out, gnt_eng})); // R6
  AST_OUT_TAG: assert property (@(posedge clk) disable iff (rst) gnt_out |=> out_rvalid && !eng_rvalid); // R7
  AST_ENG_TAG: assert property (@(posedge clk) disable iff (rst) gnt_eng && !ram_we |=> eng_rvalid && !out_rvalid); // R7
  AST_DUMP_BOUND: assert property (@(posedge clk) disable iff (rst) dump_pend |-> wait_cnt < 4'd6); // R8
  AST_LOADED_HOLD: assert property (@(posedge clk) disable iff (rst) loaded && !out_ack |=> loaded); // R9
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (phase == 4'd0 && !loaded && !dump_pend && !out_rvalid)); // R10
endmodule

bind slot_ram_sched slot_ram_sched_chk u_chk (
  .clk(clk), .rst(rst), .phase(phase), .gnt_in(gnt_in), .gnt_out(gnt_out),
  .gnt_eng(gnt_eng), .ram_en(ram_en), .ram_we(ram_we), .out_rvalid(out_rvalid),
  .eng_rvalid(eng_rvalid), .loaded(loaded), .out_ack(out_ack), .dump_pend(dump_pend)
);

// File: tb/slot_ram_sched_bench.sv
module slot_ram_sched_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_req, out_req, dump_go, out_ack, eng_req, eng_we;
  logic [AW-1:0] in_addr, out_addr, eng_addr, ram_addr;
  logic [DW-1:0] in_wdata, eng_wdata, ram_wdata, ram_rdata, out_rdata, eng_rdata;
  logic [3:0] phase;
  logic gnt_in, gnt_out, gnt_eng, ram_en, ram_we, out_rvalid, eng_rvalid, loaded;

  slot_ram_sched #(.AW(AW), .DW(DW)) u_slot_ram_sched (
    .clk(clk), .rst(rst), .in_req(in_req), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_req(out_req), .out_addr(out_addr), .dump_go(dump_go), .out_ack(out_ack),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .phase(phase), .gnt_in(gnt_in), .gnt_out(gnt_out), .gnt_eng(gnt_eng),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .out_rvalid(out_rvalid), .out_rdata(out_rdata),
    .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata), .loaded(loaded)
  );

  logic [DW-1:0] ram [WORDS];
  always @(posedge clk)
    if (ram_en) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      else        ram_rdata <= ram[ram_addr];
    end

  int total = 0, fails = 0, cyc = 0, go_cyc = 0;
  bit done = 0;
  int m_ph;
  bit m_pend, m_ld, m_orv, m_erv, prev_ld;
  logic [DW-1:0] m_rd;
  logic [DW-1:0] m_mem [WORDS];

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    bit so, si, se, g_o, g_i, g_e, en, we;
    int addr, wd;
    #1;
    so  = (m_ph == 0) || (m_ph == 6);
    si  = (m_ph == 1) || (m_ph == 7);
    se  = !so && !si;
    g_o = so && (out_req || m_pend);
    g_i = si && in_req;
    g_e = se && eng_req;
    en  = g_o || g_i || g_e;
    we  = g_i || (g_e && eng_we);
    addr = g_i ? int'(in_addr) : g_o ? int'(out_addr) : g_e ? int'(eng_addr) : 0;
    wd   = g_i ? int'(in_wdata) : (g_e && eng_we) ? int'(eng_wdata) : 0;

    chk("R1 phase", int'(phase), m_ph);
    chk("R2 gnt_out", int'(gnt_out), int'(g_o));
    chk("R3 gnt_in", int'(gnt_in), int'(g_i));
    chk("R4 gnt_eng", int'(gnt_eng), int'(g_e));
    chk("R5 ram_en", int'(ram_en), int'(en));
    chk("R6 ram_we", int'(ram_we), int'(we));
    chk("R6 ram_addr", int'(ram_addr), addr);
    chk("R6 ram_wdata", int'(ram_wdata), wd);
    chk("R7 out_rvalid", int'(out_rvalid), int'(m_orv));
    chk("R7 eng_rvalid", int'(eng_rvalid), int'(m_erv));
    chk("R7 out_rdata", int'(out_rdata), m_orv ? int'(m_rd) : 0);
    chk("R7 eng_rdata", int'(eng_rdata), m_erv ? int'(m_rd) : 0);
    chk("R9 loaded", int'(loaded), int'(m_ld));
    if (loaded && !prev_ld) chk("R8 dump latency within 7", int'((cyc - go_cyc) <= 7), 1);
    prev_ld = loaded;

    if (en) begin
      if (we) m_mem[addr] = DW'(wd);
      else    m_rd = m_mem[addr];
    end
    if (!rst && dump_go && (!m_pend || g_o)) go_cyc = cyc;
    if (rst) begin
      m_ph = 0; m_pend = 0; m_ld = 0; m_orv = 0; m_erv = 0;
    end else begin
      m_ld   = (g_o && m_pend) ? 1'b1 : (out_ack ? 1'b0 : m_ld);
      m_pend = dump_go || (m_pend && !g_o);
      m_orv  = g_o;
      m_erv  = g_e && !eng_we;
      m_ph   = (m_ph + 1) % 12;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic quiet();
    in_req = 0; out_req = 0; eng_req = 0; eng_we = 0; dump_go = 0; out_ack = 0;
    in_addr = '0; out_addr = '0; eng_addr = '0; in_wdata = '0; eng_wdata = '0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin ram[i] = '0; m_mem[i] = '0; end
    m_ph = 0; m_pend = 0; m_ld = 0; m_orv = 0; m_erv = 0; m_rd = '0; prev_ld = 0;
    rst = 1; quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    step();                       // R10 reset state
    rst = 0;
    for (int i = 0; i < 24; i++) step();   // R5 all idle
    for (int i = 0; i < 600; i++) begin    // mixed traffic
      in_req = ($urandom % 2) == 0; out_req = ($urandom % 4) == 0;
      eng_req = ($urandom % 5) < 3; eng_we = ($urandom % 2) == 0;
      in_addr = AW'($urandom); out_addr = AW'($urandom); eng_addr = AW'($urandom);
      in_wdata = DW'($urandom); eng_wdata = DW'($urandom);
      dump_go = ($urandom % 20) == 0; out_ack = ($urandom % 10) == 0;
      step();
    end
    quiet();
    for (int k = 0; k < 12; k++) begin     // R8 dump issued at every phase
      out_ack = 1; step(); out_ack = 0;
      while (m_ph != k) step();
      dump_go = 1; step(); dump_go = 0;
      for (int j = 0; j < 9; j++) step();  // R9 held without ack
    end
    out_ack = 1; dump_go = 1; step();      // R9 ack together with a new pulse
    dump_go = 0; out_ack = 0;
    for (int j = 0; j < 8; j++) step();
    out_ack = 1; step(); out_ack = 0;
    while (m_ph != 2) step();
    dump_go = 1; step(); dump_go = 0;      // R10 reset cancels pending dump
    rst = 1; step(); rst = 0;
    for (int j = 0; j < 30; j++) step();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule